// File: doc/BRIEF.md
# Dual-Channel Overload Integrator with Cooldown Timer

This block accumulates overload evidence from two output switches into one shared 8-bit level. Each clock it samples one overload-detect flag per channel. The level climbs by the number of flagged channels in that clock. It decays by one step only after ten clocks in a row without any flag. As a result, a short burst of high current is tolerated, for example when charging a capacitive load. A sustained or frequent overload is not.

When the level reaches its ceiling, the block drives an active-low error flag and requests that every switch be turned off. It then holds that state for a fixed cooldown of `OFF_CYCLES` clocks. At the end of the cooldown it clears the level to zero, lifts the error and releases the switches. The level is also exported for observation. At a 2 MHz clock, the default cooldown of 100000 clocks gives about 50 ms. A permanent single-channel overload then trips after about 128 µs.

Top module: `ovl_integ`

## Requirements
- R1: While `rst` is high (synchronous), and after the first edge with `rst` low and no overload flags, `level` is 0, `err_n` is 1 and `shutdown` is 0.
- R2: Outside cooldown, a clock edge where exactly one bit of `ovl_det` is 1 raises `level` by 1. Either bit may be the one set.
- R3: Outside cooldown, a clock edge where both bits of `ovl_det` are 1 raises `level` by 2.
- R4: `level` saturates at 255 and never wraps. A +2 step from 254 gives 255, and a +1 step from 254 gives 255.
- R5: Outside cooldown, with `ovl_det` = 0, `level` falls by 1 on the 10th consecutive overload-free edge, and on every 10th such edge after that. It stays at 0 once there.
- R6: Any edge with an overload flag restarts the count of overload-free edges. So 9 free edges, one overloaded edge and 9 more free edges produce no decrement, and the 10th free edge after the overload does.
- R7: On the edge where `level` becomes 255, `err_n` falls to 0 and `shutdown` rises to 1. From level 0, a permanent overload on one channel trips on the 255th edge, and on both channels on the 128th edge.
- R8: During cooldown, `level` holds 255 and `ovl_det` is ignored. Cooldown lasts exactly `OFF_CYCLES` edges, counting the trip edge. On the following edge `level` becomes 0, `err_n` returns to 1 and `shutdown` to 0, whatever `ovl_det` is.
- R9: With one channel, a repeating pattern of 1 overloaded edge followed by 10 free edges never trips and never lifts `level` more than 1 above its starting value.
- R10: `shutdown` is always the complement of `err_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Integrator clock |
| rst | input | 1 | Synchronous active-high reset |
| ovl_det | input | NUM_CH (2) | Per-channel overload flag, bit 0 = channel A, bit 1 = channel B |
| err_n | output | 1 | Active-low overload error |
| shutdown | output | 1 | Request to turn all switches off |
| level | output | CNT_W (8) | Current integrator level |

## Verification
Two functions can act on the same edge, and the bench provokes both cases.

- **Saturating step and trip.** A permanent dual-channel overload walks the level to 254. The next +2 step must saturate at 255 and trip the cooldown on that same edge. The bench judges this from `level`, `err_n` and `shutdown` sampled just after that edge.
- **Cooldown release and live overload.** Both overload flags are held high through the last cooldown edge. The release must still clear the level to 0 rather than add the flags.

A scoreboard compares every cycle against expected values worked out from the rules above.

// File: rtl/ovl_integ_pkg.sv
package ovl_integ_pkg;

    // Operating phase of the integrator
    typedef enum logic {
        PH_ACTIVE   = 1'b0,
        PH_COOLDOWN = 1'b1
    } phase_e;

    // Summary of one clock's overload step
    typedef struct packed {
        logic any_hit;     // at least one channel flagged
        logic at_ceiling;  // stepped level equals the ceiling
    } step_flags_t;

    // Saturating addition against a ceiling
    function automatic int unsigned sat_add(input int unsigned base,
                                            input int unsigned inc,
                                            input int unsigned ceil_v);
        int unsigned sum;
        sum = base + inc;
        return (sum > ceil_v) ? ceil_v : sum;
    endfunction

    // Width of a counter that must hold 0 .. n-1 (at least one bit)
    function automatic int unsigned ctr_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ovl_step_calc.sv
module ovl_step_calc
    import ovl_integ_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [NUM_CH-1:0] det,
    input  logic [CNT_W-1:0]  cur,
    output logic [CNT_W-1:0]  nxt,
    output step_flags_t       flags
);
    localparam int unsigned LVL_MAX = (1 << CNT_W) - 1;

    // Per-channel weight, one slice per channel
    int unsigned weight [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_weight
        assign weight[g] = det[g] ? 32'd1 : 32'd0;
    end

    int unsigned hits;

    always_comb begin
        hits = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            hits = hits + weight[i];
        end
        nxt              = CNT_W'(sat_add(32'(cur), hits, LVL_MAX));
        flags.any_hit    = (hits != 0);
        flags.at_ceiling = (nxt == CNT_W'(LVL_MAX));
    end

endmodule

// File: rtl/ovl_decay_presc.sv
module ovl_decay_presc
    import ovl_integ_pkg::*;
#(
    parameter int unsigned DECAY_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = ctr_width(DECAY_DIV);
    localparam logic [PW-1:0] LAST = PW'(DECAY_DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick = !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/ovl_off_timer.sv
module ovl_off_timer
    import ovl_integ_pkg::*;
#(
    parameter int unsigned OFF_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    output logic cooling,
    output logic release_now
);
    localparam int unsigned TW = ctr_width(OFF_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(OFF_CYCLES - 1);

    phase_e        phase_q;
    logic [TW-1:0] tmr_q;

    assign cooling     = (phase_q == PH_COOLDOWN);
    assign release_now = cooling && (tmr_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ACTIVE;
            tmr_q   <= '0;
        end else begin
            case (phase_q)
                PH_ACTIVE: begin
                    tmr_q <= '0;
                    if (trip) phase_q <= PH_COOLDOWN;
                end
                PH_COOLDOWN: begin
                    if (tmr_q == LAST) begin
                        phase_q <= PH_ACTIVE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: phase_q <= PH_ACTIVE;
            endcase
        end
    end

    // R8
    idle_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACTIVE) |-> (tmr_q == '0));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        release_now |=> !cooling);

endmodule

// File: rtl/ovl_integ.sv
module ovl_integ
    import ovl_integ_pkg::*;
#(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned DECAY_DIV  = 10,
    parameter int unsigned OFF_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ovl_det,
    output logic              err_n,
    output logic              shutdown,
    output logic [CNT_W-1:0]  level
);
    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] level_q;
    logic [CNT_W-1:0] up_level;
    step_flags_t      flags;
    logic             cooling;
    logic             release_now;
    logic             decay_tick;
    logic             trip;

    ovl_step_calc #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W)
    ) u_step (
        .det   (ovl_det),
        .cur   (level_q),
        .nxt   (up_level),
        .flags (flags)
    );

    ovl_decay_presc #(
        .DECAY_DIV (DECAY_DIV)
    ) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (flags.any_hit || cooling),
        .tick  (decay_tick)
    );

    assign trip = !cooling && flags.any_hit && flags.at_ceiling;

    ovl_off_timer #(
        .OFF_CYCLES (OFF_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .trip        (trip),
        .cooling     (cooling),
        .release_now (release_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (cooling) begin
            if (release_now) level_q <= '0;
        end else if (flags.any_hit) begin
            level_q <= up_level;
        end else if (decay_tick && level_q != '0) begin
            level_q <= level_q - 1'b1;
        end
    end

    assign level    = level_q;
    assign err_n    = !cooling;
    assign shutdown = cooling;

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && $countones(ovl_det) == 1 && level != LVL_MAX)
        |=> (level == $past(level) + 1'b1));

    // R3
    dual_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && $countones(ovl_det) == 2 && level < LVL_MAX - 1'b1)
        |=> (level == $past(level) + 2'd2));

    // R5
    decay_chk: assert property (@(posedge clk) disable iff (rst)
        (!shutdown && ovl_det == '0)
        |=> (level == $past(level)) || (level == $past(level) - 1'b1));

    // R7
    trip_chk: assert property (@(posedge clk) disable iff (rst)
        (level == LVL_MAX) |-> shutdown);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (level == LVL_MAX));

endmodule

// File: tb/ovl_integ_bench.sv
module ovl_integ_bench;

    localparam int OFF = 50;

    typedef struct {
        bit    chk;
        int    lvl;
        bit    errn;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ovl_det = 2'b00;
    logic       err_n;
    logic       shutdown;
    logic [7:0] level;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    ovl_integ #(.OFF_CYCLES(OFF)) u_ovl_integ (
        .clk      (clk),
        .rst      (rst),
        .ovl_det  (ovl_det),
        .err_n    (err_n),
        .shutdown (shutdown),
        .level    (level)
    );

    // Driver: apply one cycle of stimulus and queue what must follow the next edge
    task automatic step(input logic [1:0] d, input bit chk, input int lvl,
                        input bit errn, input string tag);
        exp_t it;
        @(negedge clk);
        ovl_det = d;
        it.chk = chk; it.lvl = lvl; it.errn = errn; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            exp_t it;
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.chk) begin
                    checks++;
                    if (int'(level) != it.lvl) begin
                        errors++;
                        $display("FAIL %s: level=%0d expected %0d", it.tag, level, it.lvl);
                    end
                    checks++;
                    if (err_n != it.errn) begin
                        errors++;
                        $display("FAIL %s: err_n=%0b expected %0b", it.tag, err_n, it.errn);
                    end
                    checks++;
                    if (shutdown != !it.errn) begin
                        errors++;
                        $display("FAIL R10 (%s): shutdown=%0b expected %0b", it.tag, shutdown, !it.errn);
                    end
                end
            end
        end
    end

    initial begin
        int lv;
        // R1: reset state
        for (int k = 0; k < 3; k++) step(2'b00, 1, 0, 1, "R1 reset");
        rst = 1'b0;
        step(2'b00, 1, 0, 1, "R1 idle after reset");

        // R2: single-channel steps, either channel
        for (int k = 1; k <= 5; k++) step(2'b01, 1, k, 1, "R2 ch A");
        for (int k = 6; k <= 8; k++) step(2'b10, 1, k, 1, "R2 ch B");

        // R3: dual-channel steps
        for (int k = 1; k <= 4; k++) step(2'b11, 1, 8 + 2 * k, 1, "R3 dual");

        // R5: decay once per ten free edges
        for (int k = 1; k <= 30; k++) step(2'b00, 1, 16 - k / 10, 1, "R5 decay");

        // R6: overload restarts the free count
        for (int k = 0; k < 9; k++) step(2'b00, 1, 13, 1, "R6 before hit");
        step(2'b01, 1, 14, 1, "R6 hit");
        for (int k = 0; k < 9; k++) step(2'b00, 1, 14, 1, "R6 restarted");
        step(2'b00, 1, 13, 1, "R6 tenth free");

        // R9: 1 on / 10 off stays bounded
        for (int r = 0; r < 20; r++) begin
            step(2'b01, 1, 14, 1, "R9 on");
            for (int k = 1; k <= 10; k++) step(2'b00, 1, (k == 10) ? 13 : 14, 1, "R9 off");
        end

        // R5: floor at zero
        for (int k = 1; k <= 150; k++) begin
            lv = 13 - k / 10;
            if (lv < 0) lv = 0;
            step(2'b00, 1, lv, 1, "R5 floor");
        end

        // R7: permanent single-channel overload trips on the 255th edge
        for (int k = 1; k <= 255; k++) step(2'b01, 1, k, (k < 255), "R7 single trip");

        // R8: cooldown holds, inputs ignored, release clears
        for (int k = 1; k < OFF; k++) step(2'b11, 1, 255, 0, "R8 hold");
        step(2'b11, 1, 0, 1, "R8 release ignores inputs");

        // R4/R7: dual overload, 254 + 2 saturates and trips on the 128th edge
        for (int k = 1; k <= 128; k++) begin
            lv = (2 * k > 255) ? 255 : 2 * k;
            step(2'b11, 1, lv, (k < 128), (k == 128) ? "R4 saturate trip" : "R7 dual ramp");
        end
        for (int k = 1; k < OFF; k++) step(2'b01, 1, 255, 0, "R8 hold dual");
        step(2'b00, 1, 0, 1, "R8 release");
        for (int k = 0; k < 12; k++) step(2'b00, 1, 0, 1, "R1 idle after cooldown");

        @(negedge clk);
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule